// File: doc/BRIEF.md
# Watchdog Timer with Lockable Tick Source

This block is a watchdog timer controlled through one 8-bit register on a simple byte bus. Its clock comes from one of five period strobes that are already divided elsewhere: two time-base taps, two watch-prescaler taps and one sub-CR timer tap. Each strobe is high for one cycle. Once the watchdog is running, it counts strobes from the chosen source. If software does not write the clear key in time, the block raises a reset request for one cycle.

In software mode the watchdog is idle after reset. Software starts it by writing the key. The tick-source select is taken from that same activating write and is frozen from then on. A strap input chooses hardware mode instead. In hardware mode the select is preset to the sub-CR tap, the upper register bits are read-only, a status bit reads 1, and counting starts straight out of reset. The prescalers and the system reset generator are outside this block.

Top module: `wdt_tick_lock`

## Requirements
- R1: The read value is {select[1:0] in bits 7:6, sub-CR flag in bit 5, hardware status in bit 4, 4'b0000 in bits 3:0}. The key nibble always reads back as zero.
- R2: With the strap low at reset, the register reads 8'h00, the watchdog is stopped and the reset request is low.
- R3: With the strap high at reset, the register reads 8'h30 (select 00, sub-CR flag 1, status 1). The watchdog counts sub-CR strobes (tick_stb[4]) with no write needed.
- R4: When the sub-CR flag is 0, select 00, 01, 10 and 11 pick tick_stb[0], [1], [2] and [3]. When the flag is 1, tick_stb[4] is used and the select bits have no effect.
- R5: A write whose bits 3:0 equal 4'b0101 (the key) starts a stopped software-mode watchdog and loads bits 7:5 from that write. A write with any other key value changes nothing: not the select, not the run state, not the count.
- R6: While the watchdog runs, bits 7:4 do not change on any write. In hardware mode they never change.
- R7: The reset request is high for exactly one cycle, in the cycle after the fourth selected strobe counted since the last clear or activation. Counting then restarts from zero.
- R8: A key write to a running watchdog zeroes its count.
- R9: A selected strobe in the same cycle as a key write is dropped, so the clear wins.
- R10: Strobes from unselected sources are ignored. In software mode, all strobes are ignored before activation.
- R11: The strap is captured at reset. Changing it afterwards has no effect.
- R12: The status bit reads 0 in software mode, including after activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; the strap is captured while it is low |
| hw_strap | input | 1 | 1 selects hardware-watchdog mode |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| tick_stb | input | 5 | One-cycle period strobes: [0] slow time-base, [1] fast time-base, [2] slow watch-prescaler, [3] fast watch-prescaler, [4] sub-CR |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench runs each select code through its own activation and counts to timeout, while it fires the other strobes all the while. A decode that mixes up sources would time out early or not at all. It tries to move the select with non-key writes and with key writes after activation, and it drives the strap high after a software reset; a design that failed to lock would show different read data. It sets a strobe on the same cycle as a clear; a design that counted that strobe would raise the request one strobe early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int WDT_REG_W  = 8;
   localparam int WDT_KEY_W  = 4;
   localparam int WDT_CS_W   = 2;
   localparam int WDT_NSRC   = (1 << WDT_CS_W) + 1;
   localparam logic [WDT_KEY_W-1:0] WDT_KEY = 4'b0101;

   typedef struct packed {
      logic [WDT_CS_W-1:0] cs;
      logic                alt;
   } wdt_sel_t;

   localparam wdt_sel_t WDT_SEL_SW_RST = '{cs: '0, alt: 1'b0};
   localparam wdt_sel_t WDT_SEL_HW_RST = '{cs: '0, alt: 1'b1};

   function automatic int unsigned wdt_src_index(input wdt_sel_t s);
      if (s.alt) return (1 << WDT_CS_W);
      return int'(s.cs);
   endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
   import wdt_pkg::*;
#(
   parameter int REG_W = WDT_REG_W,
   parameter int KEY_W = WDT_KEY_W,
   parameter logic [KEY_W-1:0] KEY = WDT_KEY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output wdt_sel_t         sel,
   output logic             run,
   output logic             hw_mode,
   output logic             clr_pulse,
   output logic [REG_W-1:0] rd_data
);

   localparam int SEL_W  = $bits(wdt_sel_t);
   localparam int STAT_B = KEY_W;
   localparam int SEL_LO = KEY_W + 1;

   generate
      if (REG_W != KEY_W + 1 + SEL_W) begin : g_bad_layout
         $error("wdt_ctrl_reg: register width does not fit key, status and select");
      end
   endgenerate

   wdt_sel_t sel_q;
   logic     run_q;
   logic     hw_q;
   logic     key_hit;
   wdt_sel_t sel_wr;

   assign key_hit = wr_en && (wr_data[KEY_W-1:0] == KEY);
   assign sel_wr  = wdt_sel_t'(wr_data[REG_W-1:SEL_LO]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hw_q  <= strap;
         run_q <= strap;
         sel_q <= strap ? WDT_SEL_HW_RST : WDT_SEL_SW_RST;
      end else if (key_hit && !run_q && !hw_q) begin
         run_q <= 1'b1;
         sel_q <= sel_wr;
      end
   end

   always_comb begin
      rd_data                  = '0;
      rd_data[REG_W-1:SEL_LO]  = sel_q;
      rd_data[STAT_B]          = hw_q;
   end

   assign sel       = sel_q;
   assign run       = run_q;
   assign hw_mode   = hw_q;
   assign clr_pulse = key_hit;

endmodule

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux
   import wdt_pkg::*;
#(
   parameter int NUM_SRC = WDT_NSRC
) (
   input  logic [NUM_SRC-1:0] tick_in,
   input  wdt_sel_t           sel,
   output logic               tick_out
);

   localparam int NUM_PRI = NUM_SRC - 1;
   localparam int ALT_IDX = NUM_SRC - 1;

   generate
      if (NUM_PRI != (1 << WDT_CS_W)) begin : g_bad_count
         $error("wdt_tick_mux: primary source count must match select width");
      end
   endgenerate

   logic [NUM_SRC-1:0] pick;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
         if (gi == ALT_IDX) begin : g_alt
            assign pick[gi] = sel.alt & tick_in[gi];
         end else begin : g_pri
            assign pick[gi] = ~sel.alt & (sel.cs == WDT_CS_W'(gi)) & tick_in[gi];
         end
      end
   endgenerate

   assign tick_out = |pick;

endmodule

// File: rtl/wdt_period_cnt.sv
module wdt_period_cnt #(
   parameter int CNT_W   = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic tick,
   output logic timeout
);

   localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("wdt_period_cnt: counter width must be at least one");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             adv;
   logic             wrap;

   assign adv  = en && tick && !clr;
   assign wrap = adv && (cnt_q == TERM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || wrap) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      if (OUT_REG) begin : g_reg_out
         logic to_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) to_q <= 1'b0;
            else        to_q <= wrap;
         end
         assign timeout = to_q;
      end else begin : g_comb_out
         assign timeout = wrap;
      end
   endgenerate

endmodule

// File: rtl/wdt_tick_lock.sv
module wdt_tick_lock
   import wdt_pkg::*;
#(
   parameter int REG_W   = WDT_REG_W,
   parameter int NUM_SRC = WDT_NSRC,
   parameter int CNT_W   = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hw_strap,
   input  logic               bus_wr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NUM_SRC-1:0] tick_stb,
   output logic               wdt_rst_req
);

   wdt_sel_t sel;
   logic     run;
   logic     hw_mode;
   logic     clr_pulse;
   logic     tick_sel;

   wdt_ctrl_reg #(
      .REG_W (REG_W),
      .KEY_W (WDT_KEY_W),
      .KEY   (WDT_KEY)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap     (hw_strap),
      .wr_en     (bus_wr),
      .wr_data   (bus_wdata),
      .sel       (sel),
      .run       (run),
      .hw_mode   (hw_mode),
      .clr_pulse (clr_pulse),
      .rd_data   (bus_rdata)
   );

   wdt_tick_mux #(
      .NUM_SRC (NUM_SRC)
   ) u_mux (
      .tick_in  (tick_stb),
      .sel      (sel),
      .tick_out (tick_sel)
   );

   wdt_period_cnt #(
      .CNT_W   (CNT_W),
      .OUT_REG (OUT_REG)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (run),
      .clr     (clr_pulse),
      .tick    (tick_sel),
      .timeout (wdt_rst_req)
   );

endmodule

// File: rtl/wdt_tick_lock_chk.sv
module wdt_tick_lock_chk #(
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [REG_W-1:0] bus_wdata,
   input logic [REG_W-1:0] bus_rdata,
   input logic             wdt_rst_req,
   input logic             run
);

   AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[3:0] == 4'b0000);                                              // R1

   AST_HW_STATUS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[4] |-> run);                                                   // R3

   AST_SELECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(bus_rdata[REG_W-1:4]));                                  // R6

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |=> !wdt_rst_req);                                           // R7

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_wdata[3:0] == 4'b0101) |=> !wdt_rst_req);                 // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !wdt_rst_req);                                                  // R10

endmodule

bind wdt_tick_lock wdt_tick_lock_chk #(.REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .wdt_rst_req (wdt_rst_req),
   .run         (run)
);

// File: tb/tb_wdt_tick_lock.sv
module tb_wdt_tick_lock;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_strap = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [4:0] tick_stb = '0;
   logic       wdt_rst_req;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   wdt_tick_lock dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .hw_strap    (hw_strap),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .tick_stb    (tick_stb),
      .wdt_rst_req (wdt_rst_req)
   );

   // Behavioural reference: state updated on each edge from the inputs held since the last falling edge
   logic [1:0] m_cs;
   logic       m_alt, m_hw, m_run, m_req;
   int         m_cnt;
   int         m_src;
   logic       m_key;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hw  = hw_strap;
         m_run = hw_strap;
         m_cs  = 2'b00;
         m_alt = hw_strap;
         m_cnt = 0;
         m_req = 1'b0;
      end else begin
         m_key = bus_wr && (bus_wdata[3:0] == 4'b0101);
         m_src = m_alt ? 4 : int'(m_cs);
         m_req = 1'b0;
         if (m_key) begin
            if (!m_run) begin
               m_run = 1'b1;
               m_cs  = bus_wdata[7:6];
               m_alt = bus_wdata[5];
            end
            m_cnt = 0;
         end else if (m_run && tick_stb[m_src]) begin
            if (m_cnt == 3) begin
               m_cnt = 0;
               m_req = 1'b1;
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
      end
   end

   // Per-cycle comparison against the reference (R1, R7 checked on every cycle)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (bus_rdata !== {m_cs, m_alt, m_hw, 4'b0000}) begin
            n_fail++;
            $display("FAIL R1 cycle %0d: rdata actual %h expected %h", cyc, bus_rdata,
                     {m_cs, m_alt, m_hw, 4'b0000});
         end
         n_chk++;
         if (wdt_rst_req !== m_req) begin
            n_fail++;
            $display("FAIL R7 cycle %0d: req actual %b expected %b", cyc, wdt_rst_req, m_req);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: run did not end, actual cycle %0d expected below 20000", cyc);
         finish_run();
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One cycle: inputs applied after a falling edge, held over the rising edge
   task automatic step(input logic wr, input logic [7:0] d, input logic [4:0] t);
      bus_wr    = wr;
      bus_wdata = d;
      tick_stb  = t;
      @(posedge clk);
      @(negedge clk);
      bus_wr   = 1'b0;
      tick_stb = '0;
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      hw_strap = strap;
      rst_n    = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ticks(input int n, input logic [4:0] t);
      for (int i = 0; i < n; i++) begin
         step(1'b0, 8'h00, t);
      end
   endtask

   initial begin
      // Software mode reset state
      do_reset(1'b0);
      chk("R2 rdata", bus_rdata, 8'h00);
      chk("R2 req", {7'b0, wdt_rst_req}, 8'h00);
      chk("R12 status", {7'b0, bus_rdata[4]}, 8'h00);

      // R10: strobes before activation
      ticks(6, 5'b11111);
      chk("R10 idle req", {7'b0, wdt_rst_req}, 8'h00);

      // R5: non-key write leaves everything untouched
      step(1'b1, 8'hE3, 5'b00000);
      chk("R5 non-key", bus_rdata, 8'h00);

      // R5: activation with select 10, flag 0 -> tick_stb[2]
      step(1'b1, 8'h85, 5'b00100);
      chk("R5 activate", bus_rdata, 8'h80);
      chk("R12 status sw", {7'b0, bus_rdata[4]}, 8'h00);

      // R6: a second key write must not move the select
      step(1'b1, 8'h65, 5'b00000);
      chk("R6 locked", bus_rdata, 8'h80);

      // R10: unselected sources
      ticks(5, 5'b11011);
      chk("R10 unselected", {7'b0, wdt_rst_req}, 8'h00);

      // R9: strobe with clear dropped
      ticks(3, 5'b00100);
      step(1'b1, 8'h05, 5'b00100);
      ticks(3, 5'b00100);
      chk("R9 dropped", {7'b0, wdt_rst_req}, 8'h00);
      ticks(1, 5'b00100);
      chk("R7 timeout", {7'b0, wdt_rst_req}, 8'h01);
      step(1'b0, 8'h00, 5'b00000);
      chk("R7 one cycle", {7'b0, wdt_rst_req}, 8'h00);

      // R8: clear mid-count
      ticks(3, 5'b00100);
      step(1'b1, 8'hF5, 5'b00000);
      ticks(3, 5'b00100);
      chk("R8 cleared", {7'b0, wdt_rst_req}, 8'h00);
      ticks(1, 5'b00100);
      chk("R8 after clear", {7'b0, wdt_rst_req}, 8'h01);

      // R4: every primary select code, with the other strobes busy
      for (int s = 0; s < 4; s++) begin
         do_reset(1'b0);
         step(1'b1, {s[1:0], 6'b000101}, 5'b00000);
         chk("R4 select read", bus_rdata, {s[1:0], 6'b000000});
         ticks(4, ~(5'b00001 << s));
         chk("R4 others ignored", {7'b0, wdt_rst_req}, 8'h00);
         ticks(4, 5'b00001 << s);
         chk("R4 selected", {7'b0, wdt_rst_req}, 8'h01);
      end

      // R4: sub-CR flag overrides select bits
      do_reset(1'b0);
      step(1'b1, 8'hE5, 5'b00000);
      chk("R4 alt read", bus_rdata, 8'hE0);
      ticks(4, 5'b01000);
      chk("R4 cs ignored", {7'b0, wdt_rst_req}, 8'h00);
      ticks(4, 5'b10000);
      chk("R4 alt timeout", {7'b0, wdt_rst_req}, 8'h01);

      // R11: strap raised after a software reset has no effect
      do_reset(1'b0);
      hw_strap = 1'b1;
      ticks(5, 5'b10000);
      chk("R11 strap late", bus_rdata, 8'h00);
      chk("R11 no run", {7'b0, wdt_rst_req}, 8'h00);

      // R3: hardware mode
      do_reset(1'b1);
      chk("R3 rdata", bus_rdata, 8'h30);
      ticks(4, 5'b01111);
      chk("R3 other src", {7'b0, wdt_rst_req}, 8'h00);
      ticks(4, 5'b10000);
      chk("R3 timeout", {7'b0, wdt_rst_req}, 8'h01);

      // R6: hardware bits never change; key still clears (R8)
      ticks(2, 5'b10000);
      step(1'b1, 8'hC5, 5'b10000);
      chk("R6 hw read-only", bus_rdata, 8'h30);
      hw_strap = 1'b0;
      ticks(3, 5'b10000);
      chk("R11 hw kept", bus_rdata, 8'h30);
      chk("R8 hw clear", {7'b0, wdt_rst_req}, 8'h00);
      ticks(1, 5'b10000);
      chk("R8 hw timeout", {7'b0, wdt_rst_req}, 8'h01);
      ticks(2, 5'b00000);

      finish_run();
   end

endmodule